// File: doc/BRIEF.md
# Dual-Width Arithmetic Unit with Condition Flags

This block is the arithmetic core of a small 8-bit processor. The accumulator is 8 bits wide and the two index registers are 16 bits wide. Each cycle it takes an operation code, a width select and two operands, and from them it forms a result, a one-hot write enable for the destination register and the next value of the condition-flag byte. The operations are add, add with carry, subtract, subtract with borrow, compare, an unsigned 8x8 multiply, a load of the interrupt level, and a hold.

The flag byte is held in a register inside the block. It carries carry, zero, negative, half-carry and signed overflow, and also a two-bit interrupt mask that encodes one of four priority levels. How the half-carry is taken depends on the operating width. In narrow mode it is the carry across the middle of the byte. In wide mode it is the carry across the middle of the 16-bit word. The multiply places its whole 16-bit product in a single index register. Instruction decode, memory access and interrupt dispatch are handled outside this block.

Top module: `dwalu_core`

## Requirements
- R1: After reset the registered flag byte reads 0x60: every arithmetic flag is clear and both mask bits are set, which is level 3.
- R2: In narrow mode (wide=0), op 0 (add) and op 1 (add plus cin) give the low byte of opa+opb (+cin for op 1) with the upper result byte zero. Only opa[7:0] and opb[7:0] are used. C is the carry out of bit 7 and H is the carry out of bit 3 into bit 4.
- R3: In wide mode (wide=1) the add operations work on all 16 bits. C is the carry out of bit 15 and H is the carry from bit 7 into bit 8.
- R4: Op 2 (subtract) and op 3 (subtract with cin as borrow) give opa-opb(-cin) modulo the width. C is the borrow out of the whole word. H is the borrow into bit 4 in narrow mode and into bit 8 in wide mode.
- R5: V marks signed overflow. For an add it is set when the operands have the same sign and the result sign differs. For a subtract it is set when the operand signs differ and the result sign differs from opa.
- R6: Z is set when the result is zero over the active width. N is the result's sign bit: bit 7 in narrow mode, bit 15 in wide mode.
- R7: Op 4 (compare) produces the same result and flags as op 2 and raises no write enable.
- R8: Op 5 (multiply) gives res = opa[7:0]*opb[7:0], unsigned and 16 bits wide, whatever the width select. Z and N are taken from the product (N = bit 15), H and C are cleared and V keeps its value. It writes Y when dst=2 and X for any other dst.
- R9: we_o bit 0 writes A, bit 1 writes X and bit 2 writes Y. For ops 0 to 3, dst codes 0, 1 and 2 select one bit each and dst 3 selects none. At most one bit is ever set.
- R10: Flag bits 6:5 hold the mask level {M1,M0}. Ops 0 to 5 leave them unchanged. Op 6 loads opb[1:0] into them, leaves the other flags as they were, outputs a result of 0 and writes no register.
- R11: The flag register takes the next-flag value at every rising clock edge. Op 7 (hold) leaves the byte unchanged, outputs a result of 0 and writes no register.
- R12: The flag layout is bit0 C, bit1 Z, bit2 N, bit3 H, bit4 V, bit5 M0, bit6 M1. Bit 7 is always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_i | input | 3 | Operation code (0..7) |
| wide_i | input | 1 | 0 = 8-bit operation, 1 = 16-bit operation |
| opa_i | input | 16 | First operand (minuend) |
| opb_i | input | 16 | Second operand |
| dst_i | input | 2 | Destination select: 0 A, 1 X, 2 Y, 3 none |
| cin_i | input | 1 | Carry or borrow in for ops 1 and 3 |
| res_o | output | 16 | Result |
| we_o | output | 3 | One-hot destination write enable {Y,X,A} |
| cc_next_o | output | 8 | Flag byte after this operation |
| cc_q_o | output | 8 | Registered flag byte |

## Verification
The assertions check, on every cycle, the properties that hold for any operand values:
- compare and multiply never raise a write enable for the accumulator;
- the write enable is never more than one-hot;
- the mask level survives every arithmetic operation;
- multiply clears H and C;
- an add of operands with mixed signs never flags overflow;
- a narrow result has a zero upper byte;
- the reserved flag bit stays clear.

Only the bench's sweeps can show that the sums, differences, borrows, half-carry positions and products are the right numbers. The sweeps cover every narrow opa value against a stride of opb values and a dense set of wide corner values. Only the bench sequences show that V carries through a multiply and that each level load reaches the registered byte.

// File: rtl/dwalu_pkg.sv
`timescale 1ns/1ps
package dwalu_pkg;

   typedef enum logic [2:0] {
      OP_ADD    = 3'd0,
      OP_ADC    = 3'd1,
      OP_SUB    = 3'd2,
      OP_SBC    = 3'd3,
      OP_CMP    = 3'd4,
      OP_MUL    = 3'd5,
      OP_SETLVL = 3'd6,
      OP_HOLD   = 3'd7
   } alu_op_e;

   localparam int CC_BITS = 8;
   localparam int CCB_C   = 0;
   localparam int CCB_Z   = 1;
   localparam int CCB_N   = 2;
   localparam int CCB_H   = 3;
   localparam int CCB_V   = 4;
   localparam int CCB_M0  = 5;
   localparam int CCB_M1  = 6;
   localparam int CCB_RSV = 7;

   localparam int DST_A    = 0;
   localparam int DST_X    = 1;
   localparam int DST_Y    = 2;
   localparam int NUM_DST  = 3;

   function automatic logic op_is_addsub(alu_op_e op);
      return op inside {OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP};
   endfunction

   function automatic logic op_is_sub(alu_op_e op);
      return op inside {OP_SUB, OP_SBC, OP_CMP};
   endfunction

   function automatic logic op_uses_cin(alu_op_e op);
      return op inside {OP_ADC, OP_SBC};
   endfunction

endpackage

// File: rtl/dwalu_addsub.sv
`timescale 1ns/1ps
// One adder/subtractor lane of width W. Reports the half-carry at bit HB.
// For subtraction, c_o and h_o are borrows and cin_i is a borrow in.
module dwalu_addsub #(
   parameter int W  = 8,
   parameter int HB = 4
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         sub_i,
   input  logic         cin_i,
   output logic [W-1:0] r_o,
   output logic         c_o,
   output logic         h_o,
   output logic         v_o
);

   if (HB < 1 || HB >= W) begin : g_bad_hb
      $error("dwalu_addsub: HB must lie inside the word");
   end

   logic [W-1:0] b_x;
   logic         ci;
   logic [W:0]   full_sum;
   logic [HB:0]  low_sum;

   always_comb begin
      b_x      = sub_i ? ~b_i : b_i;
      ci       = sub_i ^ cin_i;
      full_sum = {1'b0, a_i} + {1'b0, b_x} + {{W{1'b0}}, ci};
      low_sum  = {1'b0, a_i[HB-1:0]} + {1'b0, b_x[HB-1:0]} + {{HB{1'b0}}, ci};
      r_o      = full_sum[W-1:0];
      c_o      = full_sum[W] ^ sub_i;
      h_o      = low_sum[HB] ^ sub_i;
      v_o      = (a_i[W-1] == b_x[W-1]) && (r_o[W-1] != a_i[W-1]);
   end

   // R5: adding operands of opposite sign can never overflow
   a_r5_mixed_sign_add: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!sub_i && (a_i[W-1] != b_i[W-1])) |-> !v_o);

   // R5: subtracting operands of equal sign can never overflow
   a_r5_same_sign_sub: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sub_i && (a_i[W-1] == b_i[W-1])) |-> !v_o);

endmodule

// File: rtl/dwalu_mul.sv
`timescale 1ns/1ps
// Unsigned IW x IW multiplier. STYLE 0 uses the '*' operator;
// STYLE 1 builds an explicit shift-and-add sum of partial products.
module dwalu_mul #(
   parameter int IW    = 8,
   parameter int STYLE = 1
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic [IW-1:0]   a_i,
   input  logic [IW-1:0]   b_i,
   output logic [2*IW-1:0] p_o
);

   localparam int PW = 2 * IW;

   if (STYLE == 0) begin : g_operator
      assign p_o = PW'(a_i) * PW'(b_i);
   end else begin : g_shift_add
      logic [PW-1:0] acc;
      always_comb begin
         acc = '0;
         for (int i = 0; i < IW; i++) begin
            if (b_i[i]) acc = acc + (PW'(a_i) << i);
         end
      end
      assign p_o = acc;
   end

   // R8: a zero factor gives a zero product
   a_r8_zero_factor: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((a_i == '0) || (b_i == '0)) |-> (p_o == '0));

   // R8: multiplying by one returns the other factor unchanged
   a_r8_unit_factor: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (b_i == IW'(1)) |-> (p_o == PW'(a_i)));

endmodule

// File: rtl/dwalu_ccreg.sv
`timescale 1ns/1ps
// Condition-flag byte register with asynchronous reset.
module dwalu_ccreg
   import dwalu_pkg::*;
#(
   parameter int           W       = CC_BITS,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   if (W <= CCB_RSV) begin : g_bad_w
      $error("dwalu_ccreg: flag byte too narrow for the layout");
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_o <= RST_VAL;
      else         q_o <= d_i;
   end

   // R12: the reserved flag bit stays clear in the stored byte
   a_r12_reserved_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !q_o[CCB_RSV]);

endmodule

// File: rtl/dwalu_core.sv
`timescale 1ns/1ps
// Dual-width arithmetic unit with a registered condition-flag byte.
module dwalu_core
   import dwalu_pkg::*;
#(
   parameter int         NARROW_W  = 8,
   parameter int         WIDE_W    = 16,
   parameter int         MUL_STYLE = 1,
   parameter logic [1:0] RST_LEVEL = 2'b11
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [2:0]          op_i,
   input  logic                wide_i,
   input  logic [WIDE_W-1:0]   opa_i,
   input  logic [WIDE_W-1:0]   opb_i,
   input  logic [1:0]          dst_i,
   input  logic                cin_i,
   output logic [WIDE_W-1:0]   res_o,
   output logic [NUM_DST-1:0]  we_o,
   output logic [CC_BITS-1:0]  cc_next_o,
   output logic [CC_BITS-1:0]  cc_q_o
);

   localparam int NLANE = 2;
   localparam int DST_W = 2;
   localparam logic [CC_BITS-1:0] CC_RST =
      {1'b0, RST_LEVEL[1], RST_LEVEL[0], 5'b00000};

   if (WIDE_W != 2 * NARROW_W) begin : g_bad_width
      $error("dwalu_core: WIDE_W must be twice NARROW_W");
   end
   if (NARROW_W < 4 || (NARROW_W % 2) != 0) begin : g_bad_narrow
      $error("dwalu_core: NARROW_W must be even and at least 4");
   end
   if (MUL_STYLE < 0 || MUL_STYLE > 1) begin : g_bad_style
      $error("dwalu_core: MUL_STYLE must be 0 or 1");
   end

   alu_op_e op;
   logic    sub_sel;
   logic    cin_eff;

   assign op      = alu_op_e'(op_i);
   assign sub_sel = op_is_sub(op);
   assign cin_eff = op_uses_cin(op) & cin_i;

   // ---------------- adder lanes, one per operating width ----------------
   logic [WIDE_W-1:0] lane_r [NLANE];
   logic [NLANE-1:0]  lane_c;
   logic [NLANE-1:0]  lane_h;
   logic [NLANE-1:0]  lane_v;

   for (genvar gi = 0; gi < NLANE; gi++) begin : g_lane
      localparam int LW = (gi == 0) ? NARROW_W : WIDE_W;
      localparam int LH = (gi == 0) ? NARROW_W / 2 : NARROW_W;
      logic [LW-1:0] r_w;

      dwalu_addsub #(
         .W  (LW),
         .HB (LH)
      ) u_addsub (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .a_i    (opa_i[LW-1:0]),
         .b_i    (opb_i[LW-1:0]),
         .sub_i  (sub_sel),
         .cin_i  (cin_eff),
         .r_o    (r_w),
         .c_o    (lane_c[gi]),
         .h_o    (lane_h[gi]),
         .v_o    (lane_v[gi])
      );

      assign lane_r[gi] = WIDE_W'(r_w);
   end

   // ---------------- multiplier ----------------
   logic [WIDE_W-1:0] prod;

   dwalu_mul #(
      .IW    (NARROW_W),
      .STYLE (MUL_STYLE)
   ) u_mul (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .a_i    (opa_i[NARROW_W-1:0]),
      .b_i    (opb_i[NARROW_W-1:0]),
      .p_o    (prod)
   );

   // ---------------- result, write enable and next flags ----------------
   logic [WIDE_W-1:0]  res_c;
   logic [NUM_DST-1:0] dst_oh;
   logic [NUM_DST-1:0] we_c;
   logic [CC_BITS-1:0] cc_c;

   always_comb begin
      for (int k = 0; k < NUM_DST; k++) begin
         dst_oh[k] = (dst_i == DST_W'(k));
      end
   end

   always_comb begin
      res_c = '0;
      we_c  = '0;
      cc_c  = cc_q_o;
      if (op_is_addsub(op)) begin
         res_c       = lane_r[wide_i];
         cc_c[CCB_C] = lane_c[wide_i];
         cc_c[CCB_H] = lane_h[wide_i];
         cc_c[CCB_V] = lane_v[wide_i];
         cc_c[CCB_N] = wide_i ? res_c[WIDE_W-1] : res_c[NARROW_W-1];
         cc_c[CCB_Z] = wide_i ? (res_c == '0) : (res_c[NARROW_W-1:0] == '0);
         if (op != OP_CMP) we_c = dst_oh;
      end else if (op == OP_MUL) begin
         res_c       = prod;
         cc_c[CCB_C] = 1'b0;
         cc_c[CCB_H] = 1'b0;
         cc_c[CCB_N] = prod[WIDE_W-1];
         cc_c[CCB_Z] = (prod == '0);
         we_c[DST_Y] = dst_oh[DST_Y];
         we_c[DST_X] = !dst_oh[DST_Y];
      end else if (op == OP_SETLVL) begin
         cc_c[CCB_M1] = opb_i[1];
         cc_c[CCB_M0] = opb_i[0];
      end
      cc_c[CCB_RSV] = 1'b0;
   end

   assign res_o     = res_c;
   assign we_o      = we_c;
   assign cc_next_o = cc_c;

   dwalu_ccreg #(
      .W       (CC_BITS),
      .RST_VAL (CC_RST)
   ) u_ccreg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (cc_c),
      .q_o    (cc_q_o)
   );

   // R7: compare never writes a register
   a_r7_cmp_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op == OP_CMP) |-> (we_o == '0));

   // R8: multiply targets an index register only, with H and C cleared
   a_r8_mul_index_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op == OP_MUL) |-> (!we_o[DST_A] && $onehot(we_o[DST_Y:DST_X])));
   a_r8_mul_clears_hc: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op == OP_MUL) |-> (!cc_next_o[CCB_H] && !cc_next_o[CCB_C]));

   // R9: never more than one destination written
   a_r9_we_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(we_o));

   // R10: arithmetic keeps the interrupt level
   a_r10_level_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_is_addsub(op) || op == OP_MUL) |->
         (cc_next_o[CCB_M1:CCB_M0] == cc_q_o[CCB_M1:CCB_M0]));

   // R2: narrow results leave the upper byte clear
   a_r2_narrow_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_is_addsub(op) && !wide_i) |-> (res_o[WIDE_W-1:NARROW_W] == '0));

   // R11: hold leaves the registered byte unchanged one cycle later
   a_r11_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op == OP_HOLD) |=> $stable(cc_q_o));

endmodule

// File: tb/dwalu_core_tb_top.sv
`timescale 1ns/1ps
module dwalu_core_tb_top;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [2:0]  op;
   logic        wide;
   logic [15:0] opa, opb;
   logic [1:0]  dst;
   logic        cin;
   logic [15:0] res;
   logic [2:0]  we;
   logic [7:0]  cc_next, cc_q;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;
   int unsigned seed = 32'h1234_5678;

   always #5 clk = ~clk;

   dwalu_core dut_i (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .op_i      (op),
      .wide_i    (wide),
      .opa_i     (opa),
      .opb_i     (opb),
      .dst_i     (dst),
      .cin_i     (cin),
      .res_o     (res),
      .we_o      (we),
      .cc_next_o (cc_next),
      .cc_q_o    (cc_q)
   );

   task automatic chk(input string tag, input logic [31:0] act,
                      input logic [31:0] exp, input string what);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h (op=%0d wide=%0b a=0x%0h b=0x%0h)",
                  tag, what, act, exp, op, wide, opa, opb);
      end
   endtask

   // Reference model built from the requirements.
   task automatic model(input int o, input int w, input int a, input int b,
                        input int d, input int ci, input int ccq,
                        output int r, output int wen, output int cc,
                        output string tag);
      int msk, hk, hm, sb, aa, bb, c, h, v, z, n, rr, cie, sa, sbb, sr;
      bit s;
      msk = w ? 'hFFFF : 'hFF;
      hk  = w ? 8 : 4;
      hm  = (1 << hk) - 1;
      sb  = w ? 15 : 7;
      aa  = a & msk;
      bb  = b & msk;
      cc  = ccq & 'h7F;
      r   = 0;
      wen = 0;
      tag = "R11";
      if (o <= 4) begin
         s   = (o >= 2);
         cie = (o == 1 || o == 3) ? ci : 0;
         if (!s) begin
            rr = aa + bb + cie;
            c  = (rr >> (sb + 1)) & 1;
            h  = (((aa & hm) + (bb & hm) + cie) >> hk) & 1;
         end else begin
            rr = aa - bb - cie;
            c  = (aa < bb + cie) ? 1 : 0;
            h  = ((aa & hm) < (bb & hm) + cie) ? 1 : 0;
         end
         r   = rr & msk;
         sa  = (aa >> sb) & 1;
         sbb = (bb >> sb) & 1;
         sr  = (r >> sb) & 1;
         v   = s ? ((sa != sbb && sr != sa) ? 1 : 0) : ((sa == sbb && sr != sa) ? 1 : 0);
         n   = sr;
         z   = (r == 0) ? 1 : 0;
         cc  = (cc & 'h60) | c | (z << 1) | (n << 2) | (h << 3) | (v << 4);
         if (o != 4 && d < 3) wen = 1 << d;
         tag = (o == 4) ? "R7" : (s ? "R4" : (w ? "R3" : "R2"));
      end else if (o == 5) begin
         r   = (a & 'hFF) * (b & 'hFF);
         z   = (r == 0) ? 1 : 0;
         n   = (r >> 15) & 1;
         cc  = (cc & 'h70) | (z << 1) | (n << 2);
         wen = (d == 2) ? 4 : 2;
         tag = "R8";
      end else if (o == 6) begin
         cc  = (cc & 'h1F) | ((b & 3) << 5);
         tag = "R10";
      end
   endtask

   task automatic apply(input int o, input int w, input int a, input int b,
                        input int d, input int ci);
      int er, ewe, ecc;
      string tg;
      @(negedge clk);
      op   = o[2:0];
      wide = w[0];
      opa  = a[15:0];
      opb  = b[15:0];
      dst  = d[1:0];
      cin  = ci[0];
      #1;
      model(o, w, a, b, d, ci, int'(cc_q), er, ewe, ecc, tg);
      chk(tg,    32'(res), er, "result");
      chk("R9",  32'(we), ewe, "write enable");
      chk(tg,    32'(cc_next & 8'h09), ecc & 'h09, "carry/half-carry");
      chk("R5",  32'(cc_next & 8'h10), ecc & 'h10, "overflow");
      chk("R6",  32'(cc_next & 8'h06), ecc & 'h06, "zero/negative");
      chk("R10", 32'(cc_next & 8'h60), ecc & 'h60, "mask level");
      chk("R12", 32'(cc_next & 8'h80), 0, "reserved bit");
      @(posedge clk);
      #1;
      chk("R11", 32'(cc_q), ecc, "registered flags");
   endtask

   function automatic int rnd16();
      seed = seed * 32'd1103515245 + 32'd12345;
      return int'((seed >> 8) & 32'hFFFF);
   endfunction

   initial begin
      int corners [10] = '{0, 1, 'h7F, 'h80, 'hFF, 'h100, 'h7FFF, 'h8000, 'hFFFF, 'h0F0F};
      rst_n = 1'b0;
      op = 3'd7; wide = 1'b0; opa = '0; opb = '0; dst = 2'd0; cin = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1", 32'(cc_q), 'h60, "reset flag byte");
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", 32'(cc_q), 'h60, "flag byte after release");

      // R10: load each interrupt level, then check it survives arithmetic
      for (int lvl = 0; lvl < 4; lvl++) begin
         apply(6, 0, 'h55, lvl, 0, 0);
         apply(0, 1, 'h1234, 'h4321, lvl, 1);
      end
      apply(6, 1, 0, 'hFFFE, 1, 1);

      // R11: hold keeps the byte
      apply(7, 0, 'hFF, 'hFF, 0, 1);
      apply(7, 1, 'h8000, 'h8000, 2, 0);

      // R2 R4 R7: narrow sweep, upper operand bytes carry junk
      for (int o = 0; o <= 4; o++) begin
         for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b += 5) begin
               apply(o, 0, a | (((a * 37) & 'hFF) << 8), b | ((b ^ 'hA5) << 8),
                     (a + b) % 4, (a ^ b) & 1);
            end
         end
      end

      // R8: multiply sweep, with V set beforehand to check it is kept
      apply(0, 0, 'h7F, 1, 3, 0);
      for (int a = 0; a < 256; a++) begin
         for (int b = 0; b < 256; b += 5) begin
            apply(5, (a >> 1) & 1, a | ('hC3 << 8), b | ('h3C << 8), (a + b) % 4, 0);
         end
      end
      apply(0, 1, 'h7FFF, 1, 0, 0);
      apply(5, 0, 'hFF, 'hFF, 2, 1);
      apply(5, 0, 0, 'h37, 1, 0);

      // R3 R4 R5 R6: wide corners
      for (int o = 0; o <= 4; o++) begin
         for (int i = 0; i < 10; i++) begin
            for (int j = 0; j < 10; j++) begin
               apply(o, 1, corners[i], corners[j], (i + j) % 4, (i + j) & 1);
            end
         end
      end

      // R3 R4: wide pseudo-random
      for (int o = 0; o <= 4; o++) begin
         for (int k = 0; k < 1500; k++) begin
            apply(o, 1, rnd16(), rnd16(), k % 4, k & 1);
         end
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #1_900_000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule